// File: doc/BRIEF.md
# DMA Transfer State Sequencer

This block is the cycle-level controller that carries out one DMA service for a multi-channel DMA engine. It watches the per-channel request lines, picks the winning channel, asks the processor for the bus with a hold request and waits for the grant. It then steps through a fixed sequence of working states, driving the channel acknowledge and the memory and I/O read and write strobes. Between transfers it decides, from the channel's programmed mode, whether to keep the bus, give it back or stop the service.

The address and word-count arithmetic sits in a neighbouring register unit. That unit tells the sequencer through `last_xfer_i` that the transfer in progress is the last one of its count. The sequencer pulses `step_o` with the channel number on `chan_o` so the unit can advance that channel. At the end of a service it raises per-channel pulses that set the terminal-count status bit and that request either a reload of the starting values or the setting of the channel's mask bit.

The block moves no data, so it has no valid/ready stream edge. The only back-pressure is `ready_i`: while it is low, the sequencer holds in a wait state and keeps the strobes asserted. All other pins are plain level or single-cycle control signals.

Top module: `dma_xfer_seq`

## Requirements
- R1: After `rst_n` low or a one-cycle `clr_i`, the sequencer is idle from the next cycle. In idle, `hrq_o`, `dack_o`, all strobes and `eop_o` are 0.
- R2: Request lines are sampled on the falling clock edge. A channel whose `mask_i` bit is 1 is ignored. When several unmasked channels request at once, the lowest index wins. The choice is made only in idle.
- R3: `hrq_o` rises one cycle after an unmasked request is seen in idle. The sequencer waits in the request state until `hlda_i` is 1. `dack_o` is one-hot for the active channel only in the working states, and never while `hrq_o` is 0.
- R4: Direction codes in `dir_i` (2 bits per channel) are 01 = I/O to memory, 10 = memory to I/O, and 00 or 11 = verify. In normal timing the working states are S1, S2, S3 and S4. The read strobe is active in S2, S3 and S4, and the write strobe in S3 and S4. A verify transfer drives no strobe.
- R5: While `ready_i` is 0 at the end of S3 (normal timing) or of S2 (compressed timing, `compressed_i`=1, which skips S3), wait cycles are inserted before S4. Both strobes stay active during the wait cycles. Compressed timing has both strobes active in S2 and S4.
- R6: I/O to memory drives `ior_o` together with `memw_o`. Memory to I/O drives `memr_o` together with `iow_o`. `ior_o` and `iow_o` are never both 1, and `memr_o` and `memw_o` are never both 1.
- R7: In single mode (`xmode_i` code 01) the sequencer makes one transfer and then drops `hrq_o` for at least one cycle. It re-requests if the line is still active.
- R8: In block mode (code 10 or 11) transfers continue with `hrq_o` held high until terminal count or an external end-of-process. The request only needs to stay high until `dack_o`.
- R9: In demand mode (code 00) transfers continue until terminal count, an external end-of-process, or the request line being low at the falling edge inside S4.
- R10: When `last_xfer_i` is 1 in the final state of a transfer, that cycle pulses `eop_o` and `tc_set_o` for the channel. It also pulses `autoinit_o` if the channel's `autoinit_en_i` bit is 1, and `mask_set_o` otherwise. The sequencer then returns to idle.
- R11: If `eop_i` is seen in any working state of a transfer, the service ends after that transfer with `autoinit_o` or `mask_set_o`, but without `eop_o` or `tc_set_o` unless the count also ends.
- R12: With `mem2mem_i`=1 and channel 0 granted, a transfer runs a read half (S11..S14, `memr_o` in S12 to S14) and then a write half (S21..S24, `memw_o` in S22 to S24), with no `dack_o`. `ready_i` low extends S13 and S23. Channel 0 is stepped in S14 and channel 1 in S24, and channel 1's count ends the service.
- R13: `step_o` pulses exactly once per transfer (twice per memory-to-memory transfer), in the final state, with `chan_o` naming the channel to advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous master clear |
| dreq_i | input | NCH | Per-channel request lines, already synchronized |
| mask_i | input | NCH | Per-channel mask bits, 1 = ignore request |
| xmode_i | input | 2*NCH | Per-channel service mode: 00 demand, 01 single, 10/11 block |
| dir_i | input | 2*NCH | Per-channel direction: 01 I/O to memory, 10 memory to I/O, else verify |
| autoinit_en_i | input | NCH | Per-channel reload-on-end enable |
| compressed_i | input | 1 | Compressed timing select |
| mem2mem_i | input | 1 | Memory-to-memory enable for channel pair 0/1 |
| hlda_i | input | 1 | Bus grant from processor |
| ready_i | input | 1 | Transfer may complete; low inserts waits |
| eop_i | input | 1 | External end-of-process request |
| last_xfer_i | input | 1 | Count unit: current transfer of `chan_o` is the last |
| hrq_o | output | 1 | Hold (bus) request |
| dack_o | output | NCH | Channel acknowledge, one-hot |
| chan_o | output | CHW | Channel being served or stepped |
| ior_o | output | 1 | I/O read strobe |
| iow_o | output | 1 | I/O write strobe |
| memr_o | output | 1 | Memory read strobe |
| memw_o | output | 1 | Memory write strobe |
| step_o | output | 1 | Advance address/count of `chan_o` |
| eop_o | output | 1 | Terminal-count end-of-process pulse |
| tc_set_o | output | NCH | Set terminal-count status bit |
| autoinit_o | output | NCH | Reload starting address and count |
| mask_set_o | output | NCH | Set channel mask bit |

## Verification
Terminal count and an external end-of-process can land on the same transfer. The bench provokes this by holding `eop_i` high through a channel's last counted transfer. It then expects exactly one completion in S4 that carries `eop_o` and `tc_set_o`, a single reload pulse, and a return to idle. A second pairing is the request drop in demand mode against the next S4. The request is removed during the second transfer, and the scoreboard must see exactly two completions with no end-of-process pulse before `hrq_o` falls.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [3:0] {
    ST_SI, ST_S0, ST_S1, ST_S2, ST_S3, ST_SW, ST_S4,
    ST_M11, ST_M12, ST_M13, ST_M14,
    ST_M21, ST_M22, ST_M23, ST_M24
  } seq_st_e;

  typedef enum logic [1:0] {
    XM_DEMAND = 2'b00,
    XM_SINGLE = 2'b01,
    XM_BLOCK  = 2'b10,
    XM_BLOCKX = 2'b11
  } xmode_e;

  localparam logic [1:0] DIR_IO2MEM = 2'b01;
  localparam logic [1:0] DIR_MEM2IO = 2'b10;

endpackage

// File: rtl/dma_req_sampler.sv
module dma_req_sampler #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] dreq_i,
  output logic [NCH-1:0] dreq_s_o
);
  // Requests are captured half a cycle ahead of the state register.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) dreq_s_o <= '0;
    else        dreq_s_o <= dreq_i;
  end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req_i,
  output logic           any_o,
  output logic [CHW-1:0] pick_o
);
  logic [NCH-1:0] blocked;
  logic [NCH-1:0] gnt;

  // Chain: a channel is blocked when any lower index is requesting.
  for (genvar g = 0; g < NCH; g++) begin : g_chain
    if (g == 0) begin : g_first
      assign blocked[g] = 1'b0;
    end else begin : g_rest
      assign blocked[g] = blocked[g-1] | req_i[g-1];
    end
    assign gnt[g] = req_i[g] & ~blocked[g];
  end

  assign any_o = |req_i;

  always_comb begin
    pick_o = '0;
    for (int i = 0; i < NCH; i++) begin
      if (gnt[i]) pick_o = CHW'(i);
    end
  end
endmodule

// File: rtl/dma_strobe_gen.sv
module dma_strobe_gen
  import dma_seq_pkg::*;
(
  input  seq_st_e    state_i,
  input  logic       comp_i,
  input  logic [1:0] dir_i,
  output logic       ior_o,
  output logic       iow_o,
  output logic       memr_o,
  output logic       memw_o
);
  logic rd_win, wr_win, m_rd, m_wr;

  always_comb begin
    rd_win = state_i inside {ST_S2, ST_S3, ST_SW, ST_S4};
    wr_win = comp_i ? (state_i inside {ST_S2, ST_SW, ST_S4})
                    : (state_i inside {ST_S3, ST_SW, ST_S4});
    m_rd   = state_i inside {ST_M12, ST_M13, ST_M14};
    m_wr   = state_i inside {ST_M22, ST_M23, ST_M24};
  end

  assign ior_o  = rd_win && (dir_i == DIR_IO2MEM);
  assign memw_o = (wr_win && (dir_i == DIR_IO2MEM)) || m_wr;
  assign memr_o = (rd_win && (dir_i == DIR_MEM2IO)) || m_rd;
  assign iow_o  = wr_win && (dir_i == DIR_MEM2IO);
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             req_any_i,
  input  logic [CHW-1:0]   pick_i,
  input  logic [NCH-1:0]   dreq_s_i,
  input  logic [2*NCH-1:0] xmode_i,
  input  logic [NCH-1:0]   ai_i,
  input  logic             comp_i,
  input  logic             m2m_i,
  input  logic             hlda_i,
  input  logic             ready_i,
  input  logic             eop_i,
  input  logic             last_xfer_i,
  output seq_st_e          state_o,
  output logic [CHW-1:0]   chan_o,
  output logic             hrq_o,
  output logic [NCH-1:0]   dack_o,
  output logic             step_o,
  output logic             eop_o,
  output logic [NCH-1:0]   tc_set_o,
  output logic [NCH-1:0]   autoinit_o,
  output logic [NCH-1:0]   mask_set_o
);
  seq_st_e        state, nxt;
  logic [CHW-1:0] chan_q;
  logic           ext_end_q;
  xmode_e         cur_mode;
  logic           busy, working, ended, fin, tc, m2m_go;

  assign cur_mode = xmode_e'(xmode_i[{chan_q, 1'b0} +: 2]);
  assign busy     = !(state inside {ST_SI, ST_S0});
  assign working  = state inside {ST_S1, ST_S2, ST_S3, ST_SW, ST_S4};
  assign ended    = last_xfer_i | ext_end_q | eop_i;
  assign m2m_go   = m2m_i && (chan_q == '0);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_SI:  if (req_any_i) nxt = ST_S0;
      ST_S0:  if (hlda_i) nxt = m2m_go ? ST_M11 : ST_S1;
      ST_S1:  nxt = ST_S2;
      ST_S2:  if (comp_i) nxt = ready_i ? ST_S4 : ST_SW;
              else        nxt = ST_S3;
      ST_S3:  nxt = ready_i ? ST_S4 : ST_SW;
      ST_SW:  nxt = ready_i ? ST_S4 : ST_SW;
      ST_S4: begin
        if (ended || cur_mode == XM_SINGLE ||
            (cur_mode == XM_DEMAND && !dreq_s_i[chan_q])) nxt = ST_SI;
        else nxt = ST_S1;
      end
      ST_M11: nxt = ST_M12;
      ST_M12: nxt = ST_M13;
      ST_M13: nxt = ready_i ? ST_M14 : ST_M13;
      ST_M14: nxt = ST_M21;
      ST_M21: nxt = ST_M22;
      ST_M22: nxt = ST_M23;
      ST_M23: nxt = ready_i ? ST_M24 : ST_M23;
      ST_M24: nxt = ended ? ST_SI : ST_M11;
      default: nxt = ST_SI;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_SI;
      chan_q    <= '0;
      ext_end_q <= 1'b0;
    end else if (clr_i) begin
      state     <= ST_SI;
      ext_end_q <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_SI && req_any_i) chan_q <= pick_i;
      if (state == ST_S0)         ext_end_q <= 1'b0;
      else if (busy && eop_i)     ext_end_q <= 1'b1;
    end
  end

  assign state_o = state;
  assign chan_o  = (state inside {ST_M21, ST_M22, ST_M23, ST_M24}) ? CHW'(1) : chan_q;
  assign hrq_o   = (state != ST_SI);
  assign step_o  = state inside {ST_S4, ST_M14, ST_M24};
  assign fin     = (state inside {ST_S4, ST_M24}) && ended;
  assign tc      = (state inside {ST_S4, ST_M24}) && last_xfer_i;
  assign eop_o   = tc;

  always_comb begin
    dack_o     = '0;
    tc_set_o   = '0;
    autoinit_o = '0;
    mask_set_o = '0;
    for (int i = 0; i < NCH; i++) begin
      if (working && chan_q == CHW'(i)) dack_o[i] = 1'b1;
    end
    if (tc)  tc_set_o[chan_o] = 1'b1;
    if (fin) begin
      if (ai_i[chan_o]) autoinit_o[chan_o] = 1'b1;
      else              mask_set_o[chan_o] = 1'b1;
    end
  end

  // R5: a wait cycle with ready still low is followed by another wait cycle
  p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    (state == ST_SW && !ready_i) |=> (state == ST_SW));

  // R3: no work begins before the bus grant
  p_grant_wait_r3: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    (state == ST_S0 && !hlda_i) |=> (state == ST_S0));

  // R10: a finished service always lands in idle
  p_end_idle_r10: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    (|autoinit_o || |mask_set_o) |=> !hrq_o);

  // R7: single mode gives the bus back after every transfer
  p_single_release_r7: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    (state == ST_S4 && cur_mode == XM_SINGLE) |=> !hrq_o);
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_seq_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [NCH-1:0]   dreq_i,
  input  logic [NCH-1:0]   mask_i,
  input  logic [2*NCH-1:0] xmode_i,
  input  logic [2*NCH-1:0] dir_i,
  input  logic [NCH-1:0]   autoinit_en_i,
  input  logic             compressed_i,
  input  logic             mem2mem_i,
  input  logic             hlda_i,
  input  logic             ready_i,
  input  logic             eop_i,
  input  logic             last_xfer_i,
  output logic             hrq_o,
  output logic [NCH-1:0]   dack_o,
  output logic [CHW-1:0]   chan_o,
  output logic             ior_o,
  output logic             iow_o,
  output logic             memr_o,
  output logic             memw_o,
  output logic             step_o,
  output logic             eop_o,
  output logic [NCH-1:0]   tc_set_o,
  output logic [NCH-1:0]   autoinit_o,
  output logic [NCH-1:0]   mask_set_o
);
  logic [NCH-1:0] dreq_s;
  logic           req_any;
  logic [CHW-1:0] pick;
  seq_st_e        state;

  dma_req_sampler #(.NCH(NCH)) u_samp (
    .clk(clk), .rst_n(rst_n), .dreq_i(dreq_i), .dreq_s_o(dreq_s)
  );

  dma_prio_pick #(.NCH(NCH)) u_pick (
    .req_i(dreq_s & ~mask_i), .any_o(req_any), .pick_o(pick)
  );

  dma_seq_fsm #(.NCH(NCH)) u_fsm (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
    .req_any_i(req_any), .pick_i(pick), .dreq_s_i(dreq_s),
    .xmode_i(xmode_i), .ai_i(autoinit_en_i), .comp_i(compressed_i),
    .m2m_i(mem2mem_i), .hlda_i(hlda_i), .ready_i(ready_i), .eop_i(eop_i),
    .last_xfer_i(last_xfer_i), .state_o(state), .chan_o(chan_o),
    .hrq_o(hrq_o), .dack_o(dack_o), .step_o(step_o), .eop_o(eop_o),
    .tc_set_o(tc_set_o), .autoinit_o(autoinit_o), .mask_set_o(mask_set_o)
  );

  dma_strobe_gen u_strb (
    .state_i(state), .comp_i(compressed_i),
    .dir_i(dir_i[{chan_o, 1'b0} +: 2]),
    .ior_o(ior_o), .iow_o(iow_o), .memr_o(memr_o), .memw_o(memw_o)
  );

  // R3: at most one acknowledge, and only while the bus is held
  p_dack_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack_o));
  p_dack_hrq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack_o) |-> hrq_o);

  // R6: opposing strobes of one space never overlap
  p_no_clash_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ior_o && iow_o) && !(memr_o && memw_o));

  // R12: strobes without an acknowledge only in memory-to-memory work
  p_m2m_nodack_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((memr_o || memw_o) && !(|dack_o)) |-> mem2mem_i);
endmodule

// File: tb/dma_xfer_seq_bench.sv
module dma_xfer_seq_bench;
  localparam int NCH = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, clr, comp, m2m, ready, eop_in;
  logic [NCH-1:0] dreq, ai_en;
  logic [2*NCH-1:0] xmode, dir;
  logic [NCH-1:0] mask;
  logic [15:0] cnt [NCH];
  logic hlda, last_xfer;
  logic [1:0] hq;
  logic hrq, ior, iow, memr, memw, step, eop_out;
  logic [NCH-1:0] dack, tc_set, autoinit, mask_set;
  logic [1:0] chan;

  dma_xfer_seq #(.NCH(NCH)) u_dma_xfer_seq (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .dreq_i(dreq), .mask_i(mask),
    .xmode_i(xmode), .dir_i(dir), .autoinit_en_i(ai_en),
    .compressed_i(comp), .mem2mem_i(m2m), .hlda_i(hlda), .ready_i(ready),
    .eop_i(eop_in), .last_xfer_i(last_xfer), .hrq_o(hrq), .dack_o(dack),
    .chan_o(chan), .ior_o(ior), .iow_o(iow), .memr_o(memr), .memw_o(memw),
    .step_o(step), .eop_o(eop_out), .tc_set_o(tc_set),
    .autoinit_o(autoinit), .mask_set_o(mask_set)
  );

  // Environment: processor grant two cycles after request, count and mask unit.
  always @(posedge clk) begin
    if (!rst_n) hq <= 2'b00;
    else        hq <= {hq[0], hrq};
    if (step) cnt[chan] <= cnt[chan] - 16'd1;
    mask <= mask | mask_set;
  end
  assign hlda      = hq[1] & hrq;
  assign last_xfer = (cnt[chan] == 16'd0);

  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(input bit ok, input string msg);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  typedef struct {
    string tag;
    int ch, ior, iow, memr, memw;
    bit eop, ai, mk;
  } exp_t;
  exp_t q[$];
  exp_t e;

  task automatic push(input string tag, input int ch, input int n_ior, input int n_iow,
                      input int n_memr, input int n_memw, input bit x_eop,
                      input bit x_ai, input bit x_mk);
    exp_t t;
    t.tag = tag; t.ch = ch; t.ior = n_ior; t.iow = n_iow; t.memr = n_memr;
    t.memw = n_memw; t.eop = x_eop; t.ai = x_ai; t.mk = x_mk;
    q.push_back(t);
  endtask

  // Monitor: counts strobe cycles per transfer and compares at each step.
  int c_ior = 0, c_iow = 0, c_memr = 0, c_memw = 0;
  int rises = 0, steps = 0;
  logic hrq_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      c_ior += int'(ior); c_iow += int'(iow); c_memr += int'(memr); c_memw += int'(memw);
      if (hrq && !hrq_prev) rises++;
      hrq_prev = hrq;
      if (step) begin
        steps++;
        if (q.size() == 0) begin
          check(1'b0, $sformatf("R13 unexpected step on ch %0d act=1 exp=0", chan));
        end else begin
          e = q.pop_front();
          check(int'(chan) == e.ch && c_ior == e.ior && c_iow == e.iow &&
                c_memr == e.memr && c_memw == e.memw && eop_out == e.eop &&
                tc_set[e.ch] == e.eop && autoinit[e.ch] == e.ai && mask_set[e.ch] == e.mk,
                $sformatf("%s ch/ior/iow/memr/memw/eop/tc/ai/mk act=%0d/%0d/%0d/%0d/%0d/%0b/%0b/%0b/%0b exp=%0d/%0d/%0d/%0d/%0d/%0b/%0b/%0b/%0b",
                  e.tag, chan, c_ior, c_iow, c_memr, c_memw, eop_out, tc_set[e.ch],
                  autoinit[e.ch], mask_set[e.ch], e.ch, e.ior, e.iow, e.memr, e.memw,
                  e.eop, e.eop, e.ai, e.mk));
        end
        c_ior = 0; c_iow = 0; c_memr = 0; c_memw = 0;
      end
    end
  end

  task automatic sync_in();
    @(posedge clk); #1;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (hrq) @(negedge clk);
    repeat (3) @(negedge clk);
    sync_in();
  endtask

  task automatic wait_dack(input int ch);
    do sync_in(); while (!dack[ch]);
  endtask

  task automatic cfg(input int ch, input logic [1:0] md, input logic [1:0] dr,
                     input bit ai, input int count);
    xmode[2*ch +: 2] = md;
    dir[2*ch +: 2]   = dr;
    ai_en[ch]        = ai;
    cnt[ch]  <= 16'(count);
    mask[ch] <= 1'b0;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R13 watchdog expired act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit ok;
    rst_n = 1'b0; clr = 1'b0; comp = 1'b0; m2m = 1'b0; ready = 1'b1; eop_in = 1'b0;
    dreq = '0; ai_en = '0; xmode = '0; dir = '0;
    mask <= '1;
    for (int i = 0; i < NCH; i++) cnt[i] <= 16'hFFFF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!hrq && dack == '0 && !ior && !iow && !memr && !memw && !eop_out,
          $sformatf("R1 reset outputs act=%0b%0h%0b%0b%0b%0b%0b exp=0", hrq, dack, ior, iow, memr, memw, eop_out));

    // R2: masked request is ignored
    sync_in();
    mask[1] <= 1'b1;
    dreq[1] = 1'b1;
    ok = 1'b1;
    repeat (20) begin @(negedge clk); if (hrq) ok = 1'b0; end
    check(ok, $sformatf("R2 masked request raised hold act=%0b exp=0", !ok));
    sync_in();
    dreq[1] = 1'b0;
    wait_idle();

    // R7: single mode, two transfers, bus released in between
    cfg(2, 2'b01, 2'b01, 1'b0, 1);
    push("R7 single xfer1", 2, 3, 0, 0, 2, 0, 0, 0);
    push("R7 single xfer2 R10", 2, 3, 0, 0, 2, 1, 0, 1);
    sync_in();
    rises = 0;
    dreq[2] = 1'b1;
    do sync_in(); while (!mask[2]);
    dreq[2] = 1'b0;
    wait_idle();
    check(rises == 2, $sformatf("R7 hold rises act=%0d exp=2", rises));

    // R8: block mode, request pulse only, reload at the end
    cfg(1, 2'b10, 2'b10, 1'b1, 2);
    push("R8 block xfer1", 1, 0, 2, 3, 0, 0, 0, 0);
    push("R8 block xfer2", 1, 0, 2, 3, 0, 0, 0, 0);
    push("R8 block xfer3 R10", 1, 0, 2, 3, 0, 1, 1, 0);
    sync_in();
    rises = 0;
    dreq[1] = 1'b1;
    wait_dack(1);
    dreq[1] = 1'b0;
    wait_idle();
    check(rises == 1, $sformatf("R8 hold rises act=%0d exp=1", rises));

    // R5: three wait cycles in normal timing
    cfg(0, 2'b10, 2'b01, 1'b0, 0);
    push("R5 normal waits", 0, 6, 0, 0, 5, 1, 0, 1);
    sync_in();
    dreq[0] = 1'b1;
    wait_dack(0);
    dreq[0] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    ready = 1'b0;
    repeat (4) @(negedge clk);
    ready = 1'b1;
    wait_idle();

    // R5: compressed timing
    comp = 1'b1;
    cfg(3, 2'b11, 2'b10, 1'b0, 1);
    push("R5 compressed xfer1", 3, 0, 2, 2, 0, 0, 0, 0);
    push("R5 compressed xfer2", 3, 0, 2, 2, 0, 1, 0, 1);
    sync_in();
    dreq[3] = 1'b1;
    wait_dack(3);
    dreq[3] = 1'b0;
    wait_idle();
    comp = 1'b0;

    // R10 + R11: terminal count and external end in the same transfer
    cfg(2, 2'b10, 2'b10, 1'b1, 0);
    push("R10 R11 tc with external end", 2, 0, 2, 3, 0, 1, 1, 0);
    sync_in();
    dreq[2] = 1'b1;
    wait_dack(2);
    dreq[2] = 1'b0;
    eop_in = 1'b1;
    wait_idle();
    eop_in = 1'b0;

    // R11: external end alone stops a block service early
    cfg(2, 2'b10, 2'b10, 1'b0, 5);
    push("R11 external end only", 2, 0, 2, 3, 0, 0, 0, 1);
    sync_in();
    dreq[2] = 1'b1;
    wait_dack(2);
    dreq[2] = 1'b0;
    eop_in = 1'b1;
    sync_in();
    eop_in = 1'b0;
    wait_idle();

    // R9: demand mode stops when the request drops
    cfg(1, 2'b00, 2'b01, 1'b0, 5);
    push("R9 demand xfer1", 1, 3, 0, 0, 2, 0, 0, 0);
    push("R9 demand xfer2", 1, 3, 0, 0, 2, 0, 0, 0);
    sync_in();
    steps = 0;
    dreq[1] = 1'b1;
    do sync_in(); while (steps < 1);
    dreq[1] = 1'b0;
    wait_idle();
    check(steps == 2 && !hrq, $sformatf("R9 demand transfers act=%0d exp=2", steps));

    // R12: memory to memory, channel 0 read half, channel 1 write half
    m2m = 1'b1;
    cfg(0, 2'b10, 2'b00, 1'b0, 5);
    cfg(1, 2'b10, 2'b00, 1'b0, 0);
    push("R12 m2m read half", 0, 0, 0, 3, 0, 0, 0, 0);
    push("R12 m2m write half", 1, 0, 0, 0, 3, 1, 0, 1);
    sync_in();
    dreq[0] = 1'b1;
    do sync_in(); while (!hrq);
    dreq[0] = 1'b0;
    wait_idle();
    m2m = 1'b0;

    // R2 priority, R4 verify drives no strobe
    cfg(0, 2'b01, 2'b01, 1'b0, 0);
    cfg(3, 2'b01, 2'b00, 1'b0, 0);
    push("R2 priority low index first", 0, 3, 0, 0, 2, 1, 0, 1);
    push("R4 verify no strobes", 3, 0, 0, 0, 0, 1, 0, 1);
    sync_in();
    dreq[0] = 1'b1;
    dreq[3] = 1'b1;
    do sync_in(); while (!(mask[0] && mask[3]));
    dreq[0] = 1'b0;
    dreq[3] = 1'b0;
    wait_idle();

    // R1: master clear in the middle of a service
    cfg(1, 2'b10, 2'b01, 1'b0, 50);
    sync_in();
    dreq[1] = 1'b1;
    wait_dack(1);
    dreq[1] = 1'b0;
    clr = 1'b1;
    sync_in();
    clr = 1'b0;
    @(negedge clk);
    check(!hrq && dack == '0 && !ior && !memw,
          $sformatf("R1 clear returns idle act=%0b%0h exp=00", hrq, dack));
    repeat (4) @(negedge clk);

    check(q.size() == 0, $sformatf("R13 transfers missing act=%0d exp=0", q.size()));
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule